// File: doc/BRIEF.md
# DRAM Refresh Scheduler with Power-Up Initialization

This block keeps an asynchronous DRAM array refreshed and brings it out of power-up. After reset it holds every row and column strobe inactive for a wait that is strictly longer than the power-up settling time. It then runs a fixed burst of dummy refresh cycles, and only after the last of these does it declare the array ready. From then on an interval timer adds one owed refresh for every slice of the refresh window. The block asks the access sequencer for the bus with a request/grant handshake and, once granted, drives one refresh cycle in which the column strobes fall before the row strobes.

Owed refreshes are held in a saturating counter, so a sequencer that is slow to grant only delays refreshes and never drops one. When the count reaches a threshold, the block takes the bus without waiting for a grant. Host accesses are granted only when the array is ready and the block is not using the bus. All strobe timings are derived from the clock frequency and a speed-grade parameter and rounded up to whole cycles.

Top module: `dram_refresh_ctrl`

## Requirements
- R1: While reset is held, all row strobes, all column strobes and write enable are high, `dram_ready` is 0, `ref_busy` is 1, and `ref_req` and `acc_gnt` are 0.
- R2: After reset is released, no strobe goes low for at least POWERUP_US*CLK_MHZ+1 clock cycles.
- R3: `dram_ready` rises only after exactly INIT_CYCLES refresh cycles have completed, and once high it never falls.
- R4: In every refresh cycle the column strobes fall at least ceil(max(5 ns, write-enable setup)) cycles before the row strobes fall. The column strobes then stay low for at least ceil(10 ns) cycles after the row strobes fall.
- R5: The row strobes stay low for at least the row-active time, stay high for at least the row precharge time, and successive row-strobe falls are at least the full cycle time apart, each rounded up to whole cycles.
- R6: The column strobes stay high for at least ceil(5 ns) cycles before they fall for the next refresh cycle.
- R7: Write enable (`dram_we_n`) is high at all times.
- R8: All column strobe bits carry the same value in every cycle, and so do all row strobe bits.
- R9: After ready, a refresh cycle begins only in the cycle after one in which `ref_req` and `ref_gnt` were both 1, unless it is forced as in R10.
- R10: If no grant comes, a refresh starts without one once FORCE_THRESH refreshes are owed, and not before.
- R11: No refresh is lost. Once the owed count has drained, the number of refresh cycles since ready equals, to within one, the number of elapsed refresh intervals of REFRESH_WINDOW_US*CLK_MHZ/REFRESH_ROWS cycles. The owed counter saturates and never wraps.
- R12: `acc_gnt` is 1 only when `dram_ready`, `acc_req` are 1 and `ref_busy` is 0. When `ref_req` is 0 it is exactly that condition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ref_gnt | input | 1 | Sequencer yields the bus for a refresh |
| acc_req | input | 1 | Host access request |
| ref_req | output | 1 | Refresh owed and the strobe engine is idle |
| acc_gnt | output | 1 | Host access granted |
| dram_ras_n | output | RAS_W | Row strobes, active low |
| dram_cas_n | output | CAS_W | Column strobes, active low |
| dram_we_n | output | 1 | Write enable, active low, held high |
| ref_busy | output | 1 | Block owns the DRAM bus |
| dram_ready | output | 1 | Initialization complete |

## Verification
The bench builds the block at 50 MHz with the slower speed grade. This makes the strobe phases 1, 3 and 3 cycles, so the margins checked under R4 to R6 are only one or two cycles wide. It shrinks the power-up wait to 4 µs (201 cycles) and the refresh window to 64 rows in 256 µs (a 200-cycle interval), so that the dummy burst, about forty randomly granted intervals and a withheld-grant window all fit in one run. The force threshold is lowered to 3 on a 3-bit owed counter. As a result, the forced takeover of R10 occurs after a few intervals.

// File: rtl/dram_ref_pkg.sv
// Shared types and timing helpers for the DRAM refresh scheduler.
// Assumes all timing values are whole nanoseconds and the clock is given in MHz.
package dram_ref_pkg;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_SETUP,
        PH_ACT,
        PH_PRE
    } strobe_phase_t;

    typedef enum logic [1:0] {
        MS_WAIT,
        MS_INIT,
        MS_RUN
    } ctrl_state_t;

    // Round a nanosecond time up to clock cycles, never below one cycle.
    function automatic int ns_to_cycles(input int ns, input int mhz);
        int c;
        c = (ns * mhz + 999) / 1000;
        if (c < 1) c = 1;
        return c;
    endfunction

    function automatic int max_of(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/dram_ref_ticker.sv
// Interval timer: emits a one-cycle tick every INTERVAL enabled cycles.
// Assumes INTERVAL >= 2; the count restarts whenever the enable drops.
module dram_ref_ticker #(
    parameter int INTERVAL = 781
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic tick
);
    localparam int CW = $clog2(INTERVAL);

    logic [CW-1:0] cnt;

    // Tick on the last count of each interval.
    assign tick = en && (cnt == CW'(INTERVAL - 1));

    // Advance the interval counter while enabled.
    always_ff @(posedge clk) begin
        if (!rst_n)      cnt <= '0;
        else if (!en)    cnt <= '0;
        else if (tick)   cnt <= '0;
        else             cnt <= cnt + 1'b1;
    end

    AST_TICK_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick); // R11

endmodule

// File: rtl/dram_ref_owed.sv
// Saturating count of refreshes owed to the array.
// Assumes inc and dec may coincide, in which case the count is unchanged.
module dram_ref_owed #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    input  logic         dec,
    output logic [W-1:0] count
);
    localparam logic [W-1:0] CMAX = {W{1'b1}};

    // Update the owed count, clamping at both ends.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (inc && !dec) begin
            if (count != CMAX) count <= count + 1'b1;
        end else if (dec && !inc) begin
            if (count != '0) count <= count - 1'b1;
        end
    end

    AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (count == CMAX && inc && !dec) |=> (count == CMAX)); // R11
    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (count == '0 && dec && !inc) |=> (count == '0)); // R11

endmodule

// File: rtl/dram_ref_strobe.sv
// Strobe engine: one column-before-row refresh cycle per start pulse.
// Phases: column setup, row active, precharge. Strobes are registered.
// Assumes start is only acted on while idle; done pulses in the last precharge cycle.
module dram_ref_strobe #(
    parameter int N_SET = 1,
    parameter int N_ACT = 3,
    parameter int N_PRE = 3,
    parameter int RAS_W = 2,
    parameter int CAS_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    output logic [RAS_W-1:0] ras_n,
    output logic [CAS_W-1:0] cas_n,
    output logic             busy,
    output logic             done
);
    import dram_ref_pkg::*;

    localparam int NMAX = max_of(max_of(N_SET, N_ACT), N_PRE);
    localparam int CNW  = $clog2(NMAX + 1);

    strobe_phase_t  phase, phase_nxt;
    logic [CNW-1:0] cnt, cnt_nxt, lim_m1;
    logic           last;
    logic           cas_lvl_nxt, ras_lvl_nxt;

    // Length of the current phase, minus one.
    always_comb begin
        case (phase)
            PH_SETUP: lim_m1 = CNW'(N_SET - 1);
            PH_ACT:   lim_m1 = CNW'(N_ACT - 1);
            PH_PRE:   lim_m1 = CNW'(N_PRE - 1);
            default:  lim_m1 = '0;
        endcase
    end

    assign last = (cnt == lim_m1);
    assign busy = (phase != PH_IDLE);
    assign done = (phase == PH_PRE) && last;

    // Phase sequencing.
    always_comb begin
        phase_nxt = phase;
        cnt_nxt   = cnt + 1'b1;
        case (phase)
            PH_IDLE: begin
                cnt_nxt = '0;
                if (start) phase_nxt = PH_SETUP;
            end
            PH_SETUP: if (last) begin phase_nxt = PH_ACT; cnt_nxt = '0; end
            PH_ACT:   if (last) begin phase_nxt = PH_PRE; cnt_nxt = '0; end
            PH_PRE:   if (last) begin phase_nxt = PH_IDLE; cnt_nxt = '0; end
            default:  begin phase_nxt = PH_IDLE; cnt_nxt = '0; end
        endcase
    end

    assign cas_lvl_nxt = !(phase_nxt == PH_SETUP || phase_nxt == PH_ACT);
    assign ras_lvl_nxt = !(phase_nxt == PH_ACT);

    // Phase and counter registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_IDLE;
            cnt   <= '0;
        end else begin
            phase <= phase_nxt;
            cnt   <= cnt_nxt;
        end
    end

    // One flop per column strobe lane, all fed the same level.
    for (genvar g = 0; g < CAS_W; g++) begin : g_cas
        always_ff @(posedge clk) begin
            if (!rst_n) cas_n[g] <= 1'b1;
            else        cas_n[g] <= cas_lvl_nxt;
        end
    end

    // One flop per row strobe lane.
    for (genvar g = 0; g < RAS_W; g++) begin : g_ras
        always_ff @(posedge clk) begin
            if (!rst_n) ras_n[g] <= 1'b1;
            else        ras_n[g] <= ras_lvl_nxt;
        end
    end

    // Checker counter: consecutive cycles the row strobe has been low.
    logic [CNW:0] ras_low_run;
    always_ff @(posedge clk) begin
        if (!rst_n)                        ras_low_run <= '0;
        else if (ras_n[0])                 ras_low_run <= '0;
        else if (ras_low_run != '1)        ras_low_run <= ras_low_run + 1'b1;
    end

    AST_CAS_BEFORE_RAS: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ras_n[0]) |-> $past(cas_n[0] == 1'b0)); // R4
    AST_RAS_LOW_MIN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ras_n[0]) |-> (ras_low_run >= (CNW+1)'(N_ACT))); // R5
    AST_START_SETUP: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> (!cas_n[0] && ras_n[0])); // R4
    AST_LANES_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (cas_n == '0 || cas_n == '1) && (ras_n == '0 || ras_n == '1)); // R8

endmodule

// File: rtl/dram_refresh_ctrl.sv
// Refresh scheduler and power-up initializer for an asynchronous DRAM array.
// Power-up: quiet wait, then INIT_CYCLES dummy refreshes, then ready.
// Run: interval ticks add owed refreshes; each is done after a grant,
// or without one once FORCE_THRESH are owed. Timings derive from CLK_MHZ
// and SLOW_GRADE. Assumes the sequencer releases the bus when it grants.
module dram_refresh_ctrl #(
    parameter int CLK_MHZ           = 50,
    parameter int SLOW_GRADE        = 1,
    parameter int REFRESH_ROWS      = 4096,
    parameter int REFRESH_WINDOW_US = 64000,
    parameter int POWERUP_US        = 100,
    parameter int INIT_CYCLES       = 8,
    parameter int OWE_W             = 4,
    parameter int FORCE_THRESH      = 4,
    parameter int RAS_W             = 2,
    parameter int CAS_W             = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ref_gnt,
    input  logic             acc_req,
    output logic             ref_req,
    output logic             acc_gnt,
    output logic [RAS_W-1:0] dram_ras_n,
    output logic [CAS_W-1:0] dram_cas_n,
    output logic             dram_we_n,
    output logic             ref_busy,
    output logic             dram_ready
);
    import dram_ref_pkg::*;

    localparam int T_RAS_NS = (SLOW_GRADE != 0) ? 60 : 50;
    localparam int T_RP_NS  = (SLOW_GRADE != 0) ? 40 : 30;
    localparam int T_RC_NS  = (SLOW_GRADE != 0) ? 104 : 84;
    localparam int T_WSR_NS = (SLOW_GRADE != 0) ? 15 : 10;
    localparam int T_CSR_NS = 5;
    localparam int T_CHR_NS = 10;
    localparam int T_RPC_NS = 5;

    localparam int N_SET = max_of(ns_to_cycles(T_CSR_NS, CLK_MHZ), ns_to_cycles(T_WSR_NS, CLK_MHZ));
    localparam int N_ACT = max_of(ns_to_cycles(T_RAS_NS, CLK_MHZ), ns_to_cycles(T_CHR_NS, CLK_MHZ));
    localparam int N_PRE = max_of(max_of(ns_to_cycles(T_RP_NS, CLK_MHZ), ns_to_cycles(T_RPC_NS, CLK_MHZ)),
                                  ns_to_cycles(T_RC_NS, CLK_MHZ) - N_ACT);
    localparam int INTERVAL = (REFRESH_WINDOW_US * CLK_MHZ) / REFRESH_ROWS;
    localparam int N_PWR    = POWERUP_US * CLK_MHZ + 1;
    localparam int PW       = $clog2(N_PWR + 1);
    localparam int IW       = $clog2(INIT_CYCLES + 1);

    ctrl_state_t      state;
    logic [PW-1:0]    pwr_cnt;
    logic [IW-1:0]    init_cnt;
    logic [OWE_W-1:0] owed;
    logic             tick, eng_start, eng_busy, eng_done;
    logic             run, owe_any, force_take, start_run;

    assign run        = (state == MS_RUN);
    assign owe_any    = (owed != '0);
    assign force_take = (owed >= OWE_W'(FORCE_THRESH));
    assign start_run  = run && !eng_busy && owe_any && (ref_gnt || force_take);
    assign eng_start  = ((state == MS_INIT) && !eng_busy) || start_run;

    assign ref_req    = run && !eng_busy && owe_any;
    assign ref_busy   = !run || eng_busy;
    assign dram_ready = run;
    assign acc_gnt    = run && acc_req && !eng_busy && !start_run;
    assign dram_we_n  = 1'b1;

    // Power-up wait, dummy-refresh burst, then normal operation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= MS_WAIT;
            pwr_cnt  <= '0;
            init_cnt <= '0;
        end else begin
            case (state)
                MS_WAIT: begin
                    if (pwr_cnt == PW'(N_PWR - 1)) state <= MS_INIT;
                    else                           pwr_cnt <= pwr_cnt + 1'b1;
                end
                MS_INIT: begin
                    if (eng_done) begin
                        if (init_cnt == IW'(INIT_CYCLES - 1)) state <= MS_RUN;
                        else                                  init_cnt <= init_cnt + 1'b1;
                    end
                end
                default: state <= MS_RUN;
            endcase
        end
    end

    dram_ref_ticker #(.INTERVAL(INTERVAL)) u_ticker (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (run),
        .tick  (tick)
    );

    dram_ref_owed #(.W(OWE_W)) u_owed (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (tick),
        .dec   (run && eng_done),
        .count (owed)
    );

    dram_ref_strobe #(
        .N_SET (N_SET),
        .N_ACT (N_ACT),
        .N_PRE (N_PRE),
        .RAS_W (RAS_W),
        .CAS_W (CAS_W)
    ) u_strobe (
        .clk   (clk),
        .rst_n (rst_n),
        .start (eng_start),
        .ras_n (dram_ras_n),
        .cas_n (dram_cas_n),
        .busy  (eng_busy),
        .done  (eng_done)
    );

    AST_QUIET_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        (state == MS_WAIT) |-> (&dram_ras_n && &dram_cas_n)); // R2
    AST_READY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        dram_ready |=> dram_ready); // R3
    AST_READY_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dram_ready) |-> $past(eng_done)); // R3
    AST_GNT_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        acc_gnt |-> (dram_ready && !ref_busy && acc_req)); // R12
    AST_FORCED_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !eng_busy && force_take) |=> eng_busy); // R10
    AST_START_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !eng_busy && !ref_req) |=> !eng_busy); // R9

endmodule

// File: tb/dram_refresh_ctrl_test.sv
// Bench: directed reset and power-up checks, random grant/request traffic,
// a withheld-grant window and a final refresh-count reconciliation.
module dram_refresh_ctrl_test;

    localparam int MHZ    = 50;
    localparam int PWR_US = 4;
    localparam int WIN_US = 256;
    localparam int ROWS   = 64;
    localparam int THRESH = 3;
    localparam int OWEW   = 3;
    localparam int NINIT  = 8;
    localparam int RASW   = 2;
    localparam int CASW   = 8;

    function automatic int cyc_of(input int ns);
        int c;
        c = (ns * MHZ + 999) / 1000;
        return (c < 1) ? 1 : c;
    endfunction
    function automatic int mx(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    localparam int E_SET  = 1;
    localparam int E_RAS  = 3;
    localparam int E_CHR  = 1;
    localparam int E_RP   = 2;
    localparam int E_RC   = 6;
    localparam int E_RPC  = 1;
    localparam int E_PWR  = PWR_US * MHZ + 1;
    localparam int E_INTV = WIN_US * MHZ / ROWS;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            ref_gnt = 1'b0;
    logic            acc_req = 1'b0;
    logic            ref_req, acc_gnt, we_n, busy, ready;
    logic [RASW-1:0] ras_n;
    logic [CASW-1:0] cas_n;

    dram_refresh_ctrl #(
        .CLK_MHZ(MHZ), .SLOW_GRADE(1), .REFRESH_ROWS(ROWS), .REFRESH_WINDOW_US(WIN_US),
        .POWERUP_US(PWR_US), .INIT_CYCLES(NINIT), .OWE_W(OWEW), .FORCE_THRESH(THRESH),
        .RAS_W(RASW), .CAS_W(CASW)
    ) uut (
        .clk(clk), .rst_n(rst_n), .ref_gnt(ref_gnt), .acc_req(acc_req),
        .ref_req(ref_req), .acc_gnt(acc_gnt), .dram_ras_n(ras_n), .dram_cas_n(cas_n),
        .dram_we_n(we_n), .ref_busy(busy), .dram_ready(ready)
    );

    always #10 clk = ~clk;

    int n_checks = 0;
    int n_fail   = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Monitor state
    bit mon_en = 0, fw_active = 0, seen_fall = 0, seen_cas = 0;
    int cyc = 0, ras_len = 0, cas_len = 0, last_fall = 0, ras_fall_cyc = 0;
    int init_falls = 0, run_falls = 0, run_cycles = 0, fw_start = 0, fw_first = -1;
    logic p_ras = 1'b1, p_cas = 1'b1, p_gnt = 1'b0, p_req = 1'b0, p_ready = 1'b0;

    always @(negedge clk) begin
        if (mon_en) begin
            cyc++;
            chk(we_n == 1'b1, "R7", int'(we_n), 1);
            chk((ras_n == '0 || ras_n == '1) && (cas_n == '0 || cas_n == '1), "R8",
                int'(cas_n), 0);
            if (cyc < E_PWR)
                chk(&ras_n && &cas_n, "R2", int'(cas_n), 255);
            if (p_ras && !ras_n[0]) begin
                chk(!p_cas && cas_len >= E_SET, "R4", cas_len, E_SET);
                if (seen_fall) begin
                    chk(ras_len >= E_RP, "R5", ras_len, E_RP);
                    chk(cyc - last_fall >= E_RC, "R5", cyc - last_fall, E_RC);
                end else begin
                    chk(cyc >= E_PWR, "R2", cyc, E_PWR);
                end
                seen_fall = 1; last_fall = cyc; ras_fall_cyc = cyc;
                if (ready) run_falls++; else init_falls++;
            end
            if (!p_ras && ras_n[0])
                chk(ras_len >= E_RAS, "R5", ras_len, E_RAS);
            if (p_cas && !cas_n[0]) begin
                if (seen_cas) chk(cas_len >= E_RPC, "R6", cas_len, E_RPC);
                seen_cas = 1;
                if (ready) begin
                    if (fw_active) begin
                        if (fw_first < 0) begin
                            fw_first = cyc;
                            chk(cyc - fw_start >= (THRESH - 1) * E_INTV, "R10",
                                cyc - fw_start, (THRESH - 1) * E_INTV);
                        end
                    end else begin
                        chk(p_gnt && p_req, "R9", int'({p_gnt, p_req}), 3);
                    end
                end
            end
            if (!p_cas && cas_n[0])
                chk(cyc - ras_fall_cyc >= E_CHR, "R4", cyc - ras_fall_cyc, E_CHR);
            if (p_ready && !ready) chk(0, "R3", 0, 1);
            if (!p_ready && ready) chk(init_falls == NINIT, "R3", init_falls, NINIT);
            if (ready) run_cycles++;
            if (acc_gnt) chk(ready && acc_req && !busy, "R12", int'({ready, acc_req, busy}), 6);
            else if (!ref_req) chk(!(ready && acc_req && !busy), "R12", int'(acc_gnt), 1);
            ras_len = (ras_n[0] == p_ras) ? ras_len + 1 : 1;
            cas_len = (cas_n[0] == p_cas) ? cas_len + 1 : 1;
            p_ras = ras_n[0]; p_cas = cas_n[0];
            p_gnt = ref_gnt; p_req = ref_req; p_ready = ready;
        end
    end

    task automatic drain();
        ref_gnt = 1'b1;
        for (int i = 0; i < 200; i++) begin
            @(posedge clk); #1;
            if (!ref_req && !busy) break;
        end
    endtask

    initial begin
        int exp_ref;
        void'($urandom(32'd2024));
        acc_req = 1'b1;
        repeat (4) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        chk(ras_n == '1, "R1", int'(ras_n), 3);
        chk(cas_n == '1, "R1", int'(cas_n), 255);
        chk(we_n == 1'b1, "R1", int'(we_n), 1);
        chk(ready == 1'b0, "R1", int'(ready), 0);
        chk(busy == 1'b1, "R1", int'(busy), 1);
        chk(ref_req == 1'b0, "R1", int'(ref_req), 0);
        chk(acc_gnt == 1'b0, "R1", int'(acc_gnt), 0);
        @(posedge clk); #1;
        rst_n = 1'b1;
        mon_en = 1;
        // Power-up and dummy burst with host requests pending (R2, R3, R12)
        for (int i = 0; i < E_PWR + 300; i++) begin
            @(posedge clk); #1;
            acc_req = $urandom % 2;
            if (ready) break;
        end
        chk(ready == 1'b1, "R3", int'(ready), 1);
        // Random grants and host traffic (R4-R9, R12)
        repeat (40 * E_INTV) begin
            @(posedge clk); #1;
            ref_gnt = $urandom % 2;
            acc_req = $urandom % 2;
        end
        // Directed: host holding request while refreshes owed (R12)
        acc_req = 1'b1;
        drain();
        // Withheld grant: forced refresh (R10)
        fw_start = cyc; fw_first = -1; fw_active = 1;
        ref_gnt = 1'b0;
        repeat (5 * E_INTV) begin
            @(posedge clk); #1;
            acc_req = $urandom % 2;
        end
        chk(fw_first >= 0 && fw_first - fw_start <= THRESH * E_INTV + 20, "R10",
            fw_first - fw_start, THRESH * E_INTV);
        fw_active = 0;
        // Reconcile refresh count with elapsed intervals (R11)
        drain();
        repeat (E_INTV / 2) begin @(posedge clk); #1; end
        drain();
        @(negedge clk);
        exp_ref = (run_cycles - 1) / E_INTV;
        chk(run_falls >= exp_ref - 1 && run_falls <= exp_ref + 1, "R11", run_falls, exp_ref);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 100000, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule